// File: doc/BRIEF.md
# Alarm, Timer and Interrupt Controller

This block sits beside the time-keeping counter chain of a real-time clock. It watches the running counter values (hundredths, seconds, minutes, hours, the packed year/date byte and the packed weekday/month byte). It compares them against a bank of alarm registers, and a configuration byte selects one of three alarm types: daily, weekday or dated. It also runs a two-digit BCD timer that advances on one of five unit ticks from the counter chain. When that timer wraps, or reaches a programmed value, the timer flag is raised.

Both the alarm flag and the timer flag live in a control/status byte and stay set until software rewrites that byte. The interrupt pin is an open-drain, active-low output, modelled here as a "pull low" enable. While alarms are disabled, the pin instead carries a free-running square wave derived from the hundredths tick, beginning in the released state. Registers are reached through a simple word-addressed write port and a combinational read port.

The pin is driven by a three-state machine. `IRQ_SQUARE` is the reset state and is used while alarms are off. `IRQ_QUIET` means alarms are on and no interrupt is pending. `IRQ_ACTIVE` means the pin is pulled low. The transitions are as follows:
- Enabling alarms moves `IRQ_SQUARE` to `IRQ_QUIET`.
- A flag with interrupt enable moves `IRQ_QUIET` to `IRQ_ACTIVE`.
- Losing every flag, or losing interrupt enable, moves `IRQ_ACTIVE` back to `IRQ_QUIET`.
- Disabling alarms returns either armed state to `IRQ_SQUARE`.

Top module: `wake_alarm_unit`

## Requirements
- R1: After reset, addresses 0, 7 and 8 to 15 read 0x00 and `int_pull_low` is 0.
- R2: Writes to address 0 (control/status), 7 (timer) and 8 to 15 (alarm bank) read back unchanged. Addresses 1 to 6 read 0x00, and writes to them have no effect.
- R3: The timer at address 7 counts BCD 00..99. It advances one step per pulse of the selected `unit_tick` bit (bit 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 days), and other tick bits are ignored. Control/status bit 2 is the alarm enable. While it is set, the unit comes from alarm-control (address 8) bits 2:0: 1 to 5 select tick bits 0 to 4, and any other code stops the timer. While it is clear, the timer counts days.
- R4: A timer step from 99 to 00 sets the timer flag, which is control/status bit 0.
- R5: While the alarm enable and alarm-control bit 3 are set, the timer becoming equal to address 15 sets the timer flag.
- R6: With alarm-control bits 5:4 = 01 (daily), a match fires when hundredths, seconds, minutes and hours equal addresses 9, 10, 11 and 12 in every bit. The date, year, month and weekday are ignored.
- R7: With bits 5:4 = 10 (weekday), the daily fields must match. In addition, the bit of address 14 indexed by the current weekday (`cnt_wdmon[7:5]`) must be 1.
- R8: With bits 5:4 = 11 (dated), the daily fields must match, and so must the date (`cnt_yrdate[5:0]` against address 13 bits 5:0) and the month (`cnt_wdmon[4:0]` against address 14 bits 4:0). The year (`cnt_yrdate[7:6]`) and weekday bits are ignored.
- R9: The alarm flag (control/status bit 1) is set only in the first cycle of a match. A match held after the flag is cleared does not set it again. Type 00, or a clear alarm enable, never sets it.
- R10: Flags stay set until a write to address 0. A flag event in the same cycle as that write wins over the written value.
- R11: With alarm enable and alarm-control bit 7 set, the pin is pulled low from the cycle after either flag is set. It is released one cycle after both flags clear or bit 7 clears.
- R12: While alarm enable is clear, the pin toggles every `SQW_HALF` (50) hundredths ticks, starting released. The phase restarts released whenever alarms are enabled and later disabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| cnt_hsec | input | 8 | Current hundredths (BCD) |
| cnt_sec | input | 8 | Current seconds (BCD) |
| cnt_min | input | 8 | Current minutes (BCD) |
| cnt_hour | input | 8 | Current hours, including format bits |
| cnt_yrdate | input | 8 | Year in bits 7:6, date in bits 5:0 |
| cnt_wdmon | input | 8 | Weekday in bits 7:5, month in bits 4:0 |
| unit_tick | input | 5 | One-cycle unit boundary pulses |
| int_pull_low | output | 1 | 1 pulls the open-drain interrupt pin low |

## Verification
The hardest situation to bring about is a flag event that lands in the very cycle software clears the status byte. Both the write and the event must reach the same clock edge. The bench drives the matching counter values and the clearing write on the same falling edge, so that the alarm's rising match and the write meet at the next rising edge. The no-retrigger rule also needs a match that stays present across a clear. The bench holds the counters steady through the write and then reads the status byte back.

// File: rtl/wau_pkg.sv
package wau_pkg;
    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_TMR   = 7;
    localparam int BANK_BASE  = 8;
    localparam int BANK_WORDS = 8;

    localparam int CT_TFLAG = 0;
    localparam int CT_AFLAG = 1;
    localparam int CT_AEN   = 2;

    localparam int AC_IE    = 7;
    localparam int AC_TALM  = 3;

    typedef enum logic [1:0] {
        ALM_OFF     = 2'b00,
        ALM_DAILY   = 2'b01,
        ALM_WEEKDAY = 2'b10,
        ALM_DATED   = 2'b11
    } alm_kind_e;

    typedef enum logic [1:0] {
        IRQ_SQUARE = 2'd0,
        IRQ_QUIET  = 2'd1,
        IRQ_ACTIVE = 2'd2
    } irq_state_e;
endpackage

// File: rtl/wau_regbank.sv
module wau_regbank #(
    parameter int DW   = 8,
    parameter int AW   = 4,
    parameter int BANK = wau_pkg::BANK_WORDS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wdata,
    input  logic [DW-1:0]            tmr_val,
    input  logic                     tset,
    input  logic                     aset,
    output logic [DW-1:0]            ctrl_q,
    output logic [BANK-1:0][DW-1:0]  bank_q,
    output logic [DW-1:0]            rdata
);
    import wau_pkg::*;

    localparam int BW = $clog2(BANK);

    logic wr_ctrl;
    assign wr_ctrl = wr && (addr == AW'(ADDR_CTRL));

    // Status byte: software value with flag events ORed on top
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            logic [DW-1:0] nxt;
            nxt = wr_ctrl ? wdata : ctrl_q;
            nxt[CT_TFLAG] = nxt[CT_TFLAG] | tset;
            nxt[CT_AFLAG] = nxt[CT_AFLAG] | aset;
            ctrl_q <= nxt;
        end
    end

    // Alarm bank (plain storage while alarms are off)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            for (int i = 0; i < BANK; i++) begin
                if (wr && (addr == AW'(BANK_BASE + i))) begin
                    bank_q[i] <= wdata;
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(ADDR_CTRL)) begin
            rdata = ctrl_q;
        end else if (addr == AW'(ADDR_TMR)) begin
            rdata = tmr_val;
        end else if (addr >= AW'(BANK_BASE)) begin
            rdata = bank_q[addr[BW-1:0]];
        end
    end

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CT_AFLAG] && !wr_ctrl) |=> ctrl_q[CT_AFLAG]);
    p_tflag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CT_TFLAG] && !wr_ctrl) |=> ctrl_q[CT_TFLAG]);
endmodule

// File: rtl/wau_timer.sv
module wau_timer #(
    parameter int UNITS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [7:0]       ldata,
    input  logic [2:0]       unit_sel,
    input  logic [UNITS-1:0] tick,
    input  logic             armed,
    input  logic [7:0]       cmp_val,
    output logic [7:0]       tmr_q,
    output logic             flag_set
);
    logic step;
    logic wrap;
    logic hit;
    logic hit_q;

    // Unit code 1..UNITS selects tick bit code-1
    always_comb begin
        step = 1'b0;
        for (int u = 0; u < UNITS; u++) begin
            if (unit_sel == 3'(u + 1)) begin
                step = tick[u];
            end
        end
    end

    assign wrap = step && !load && (tmr_q == 8'h99);
    assign hit  = armed && (tmr_q == cmp_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (load) begin
            tmr_q <= ldata;
        end else if (step) begin
            if (tmr_q[3:0] >= 4'd9) begin
                tmr_q[3:0] <= 4'd0;
                tmr_q[7:4] <= (tmr_q[7:4] >= 4'd9) ? 4'd0 : tmr_q[7:4] + 4'd1;
            end else begin
                tmr_q[3:0] <= tmr_q[3:0] + 4'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit;
    end

    assign flag_set = wrap || (hit && !hit_q);

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q == 8'h99 && step && !load) |=> (tmr_q == 8'h00));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(tmr_q));
endmodule

// File: rtl/wau_match.sv
module wau_match (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alm_en,
    input  logic [1:0] kind,
    input  logic [7:0] c_hsec,
    input  logic [7:0] c_sec,
    input  logic [7:0] c_min,
    input  logic [7:0] c_hour,
    input  logic [7:0] c_yd,
    input  logic [7:0] c_wm,
    input  logic [7:0] a_hsec,
    input  logic [7:0] a_sec,
    input  logic [7:0] a_min,
    input  logic [7:0] a_hour,
    input  logic [7:0] a_yd,
    input  logic [7:0] a_wm,
    output logic       set_pulse
);
    import wau_pkg::*;

    logic daily_eq;
    logic hit;
    logic hit_q;
    alm_kind_e k;

    assign k = alm_kind_e'(kind);
    assign daily_eq = (c_hsec == a_hsec) && (c_sec == a_sec) &&
                      (c_min == a_min) && (c_hour == a_hour);

    always_comb begin
        hit = 1'b0;
        if (alm_en) begin
            unique case (k)
                ALM_OFF:     hit = 1'b0;
                ALM_DAILY:   hit = daily_eq;
                ALM_WEEKDAY: hit = daily_eq && a_wm[c_wm[7:5]];
                ALM_DATED:   hit = daily_eq && (c_yd[5:0] == a_yd[5:0]) &&
                                   (c_wm[4:0] == a_wm[4:0]);
                default:     hit = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit;
    end

    assign set_pulse = hit && !hit_q;

    p_one_shot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> !set_pulse);
endmodule

// File: rtl/wau_irq.sv
module wau_irq #(
    parameter int SQW_HALF = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alm_en,
    input  logic ie,
    input  logic flag_any,
    input  logic hs_tick,
    output logic pull_low
);
    import wau_pkg::*;

    localparam int CW = (SQW_HALF > 1) ? $clog2(SQW_HALF) : 1;

    irq_state_e state_q, state_d;
    logic [CW-1:0] sq_cnt;
    logic          sq_phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_SQUARE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_SQUARE: if (alm_en) state_d = IRQ_QUIET;
            IRQ_QUIET: begin
                if (!alm_en)             state_d = IRQ_SQUARE;
                else if (ie && flag_any) state_d = IRQ_ACTIVE;
            end
            IRQ_ACTIVE: begin
                if (!alm_en)                state_d = IRQ_SQUARE;
                else if (!(ie && flag_any)) state_d = IRQ_QUIET;
            end
            default: state_d = IRQ_SQUARE;
        endcase
    end

    // Square-wave divider, only running in IRQ_SQUARE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_cnt   <= '0;
            sq_phase <= 1'b0;
        end else if (state_q != IRQ_SQUARE) begin
            sq_cnt   <= '0;
            sq_phase <= 1'b0;
        end else if (hs_tick) begin
            if (sq_cnt == CW'(SQW_HALF - 1)) begin
                sq_cnt   <= '0;
                sq_phase <= !sq_phase;
            end else begin
                sq_cnt <= sq_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            IRQ_SQUARE: pull_low = sq_phase;
            IRQ_QUIET:  pull_low = 1'b0;
            IRQ_ACTIVE: pull_low = 1'b1;
            default:    pull_low = 1'b0;
        endcase
    end

    p_no_active_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !alm_en |=> (state_q != IRQ_ACTIVE));
    p_square_left_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_en) |=> (state_q != IRQ_SQUARE));
    p_quiet_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_en && !flag_any) |=> !(state_q == IRQ_ACTIVE && $past(state_q) != IRQ_ACTIVE));
endmodule

// File: rtl/wake_alarm_unit.sv
module wake_alarm_unit #(
    parameter int SQW_HALF = 50,
    parameter int UNITS    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [3:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic [7:0]       cnt_hsec,
    input  logic [7:0]       cnt_sec,
    input  logic [7:0]       cnt_min,
    input  logic [7:0]       cnt_hour,
    input  logic [7:0]       cnt_yrdate,
    input  logic [7:0]       cnt_wdmon,
    input  logic [UNITS-1:0] unit_tick,
    output logic             int_pull_low
);
    import wau_pkg::*;

    localparam int DW = 8;
    localparam int AW = 4;
    localparam logic [2:0] DAY_UNIT = 3'(UNITS);

    logic [DW-1:0]                 ctrl;
    logic [BANK_WORDS-1:0][DW-1:0] bank;
    logic [DW-1:0]                 tmr;
    logic                          tset, aset;
    logic                          alm_en;
    logic [DW-1:0]                 actl;
    logic [2:0]                    unit_sel;

    assign alm_en   = ctrl[CT_AEN];
    assign actl     = bank[0];
    assign unit_sel = alm_en ? actl[2:0] : DAY_UNIT;

    wau_regbank #(.DW(DW), .AW(AW), .BANK(BANK_WORDS)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .tmr_val(tmr), .tset(tset), .aset(aset),
        .ctrl_q(ctrl), .bank_q(bank), .rdata(bus_rdata)
    );

    wau_timer #(.UNITS(UNITS)) tmr_i (
        .clk(clk), .rst_n(rst_n),
        .load(bus_wr && (bus_addr == AW'(ADDR_TMR))),
        .ldata(bus_wdata), .unit_sel(unit_sel), .tick(unit_tick),
        .armed(alm_en && actl[AC_TALM]), .cmp_val(bank[7]),
        .tmr_q(tmr), .flag_set(tset)
    );

    wau_match match_i (
        .clk(clk), .rst_n(rst_n), .alm_en(alm_en), .kind(actl[5:4]),
        .c_hsec(cnt_hsec), .c_sec(cnt_sec), .c_min(cnt_min),
        .c_hour(cnt_hour), .c_yd(cnt_yrdate), .c_wm(cnt_wdmon),
        .a_hsec(bank[1]), .a_sec(bank[2]), .a_min(bank[3]),
        .a_hour(bank[4]), .a_yd(bank[5]), .a_wm(bank[6]),
        .set_pulse(aset)
    );

    wau_irq #(.SQW_HALF(SQW_HALF)) irq_i (
        .clk(clk), .rst_n(rst_n), .alm_en(alm_en), .ie(actl[AC_IE]),
        .flag_any(ctrl[CT_TFLAG] || ctrl[CT_AFLAG]), .hs_tick(unit_tick[0]),
        .pull_low(int_pull_low)
    );

    p_no_alarm_flag_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!alm_en && !ctrl[CT_AFLAG] && !(bus_wr && bus_addr == AW'(ADDR_CTRL)))
        |=> !ctrl[CT_AFLAG]);
endmodule

// File: tb/wake_alarm_unit_tb_top.sv
`timescale 1ns/1ps
module wake_alarm_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] c_hs = '0, c_s = '0, c_m = '0, c_h = '0, c_yd = '0, c_wm = '0;
    logic [4:0] tick = '0;
    logic       pin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = !clk;

    wake_alarm_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_hsec(c_hs), .cnt_sec(c_s), .cnt_min(c_m), .cnt_hour(c_h),
        .cnt_yrdate(c_yd), .cnt_wdmon(c_wm), .unit_tick(tick),
        .int_pull_low(pin)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_ctrl;
    logic [7:0] m_bank [8];
    logic [7:0] m_tmr;
    bit         m_aq, m_tq, m_phase;
    int         m_sq;
    int         m_st;   // 0 square, 1 quiet, 2 active

    function automatic logic [7:0] m_read(input logic [3:0] a);
        if (a == 4'd0) return m_ctrl;
        if (a == 4'd7) return m_tmr;
        if (a >= 4'd8) return m_bank[a - 4'd8];
        return 8'h00;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = 0; m_tmr = 0; m_aq = 0; m_tq = 0; m_phase = 0; m_sq = 0; m_st = 0;
            foreach (m_bank[i]) m_bank[i] = 0;
        end else begin
            bit en, step, ovf, tm, am, daily, ie, fl;
            int sel, v, nst;
            logic [7:0] ac, nctrl, ntmr;
            en = m_ctrl[2];
            ac = m_bank[0];
            sel = en ? int'(ac[2:0]) : 5;
            step = (sel >= 1 && sel <= 5) ? tick[sel-1] : 1'b0;
            ovf = 0;
            ntmr = m_tmr;
            if (bus_wr && bus_addr == 4'd7) ntmr = bus_wdata;
            else if (step) begin
                v = int'(m_tmr[7:4]) * 10 + int'(m_tmr[3:0]);
                if (v == 99) begin ntmr = 8'h00; ovf = 1; end
                else begin v = v + 1; ntmr = {4'(v / 10), 4'(v % 10)}; end
            end
            tm = en && ac[3] && (m_tmr == m_bank[7]);
            daily = (c_hs == m_bank[1]) && (c_s == m_bank[2]) &&
                    (c_m == m_bank[3]) && (c_h == m_bank[4]);
            am = 0;
            if (en) begin
                case (ac[5:4])
                    2'b01: am = daily;
                    2'b10: am = daily && m_bank[6][c_wm[7:5]];
                    2'b11: am = daily && (c_yd[5:0] == m_bank[5][5:0]) &&
                                (c_wm[4:0] == m_bank[6][4:0]);
                    default: am = 0;
                endcase
            end
            nctrl = (bus_wr && bus_addr == 4'd0) ? bus_wdata : m_ctrl;
            nctrl[0] = nctrl[0] | ovf | (tm && !m_tq);
            nctrl[1] = nctrl[1] | (am && !m_aq);
            // pin state machine, from current values
            ie = ac[7];
            fl = m_ctrl[0] | m_ctrl[1];
            if (m_st == 0) begin
                if (tick[0]) begin
                    if (m_sq == 49) begin m_sq = 0; m_phase = !m_phase; end
                    else m_sq = m_sq + 1;
                end
            end else begin
                m_sq = 0; m_phase = 0;
            end
            nst = m_st;
            if (m_st == 0) begin if (en) nst = 1; end
            else if (!en) nst = 0;
            else if (m_st == 1 && ie && fl) nst = 2;
            else if (m_st == 2 && !(ie && fl)) nst = 1;
            m_st = nst;
            m_tq = tm; m_aq = am;
            m_tmr = ntmr;
            m_ctrl = nctrl;
            if (bus_wr && bus_addr >= 4'd8) m_bank[bus_addr - 4'd8] = bus_wdata;
        end
    end

    // cycle-by-cycle comparison, a quarter period after each rising edge
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            bit mp;
            mp = (m_st == 2) || (m_st == 0 && m_phase);
            checks++;
            if (pin !== mp) begin
                errors++;
                $display("FAIL R11 pin per-cycle: actual=%0b expected=%0b at %0t", pin, mp, $time);
            end
            checks++;
            if (bus_rdata !== m_read(bus_addr)) begin
                errors++;
                $display("FAIL R2 rdata per-cycle addr=%0h: actual=%02h expected=%02h",
                         bus_addr, bus_rdata, m_read(bus_addr));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd_check(input logic [3:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        @(posedge clk);
        #5;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr=%0h: actual=%02h expected=%02h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic pin_check(input bit exp, input string req);
        @(posedge clk);
        #5;
        checks++;
        if (pin !== exp) begin
            errors++;
            $display("FAIL %s pin: actual=%0b expected=%0b", req, pin, exp);
        end
    endtask

    task automatic pulse(input int idx, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick[idx] = 1'b1;
            @(negedge clk); tick[idx] = 1'b0;
        end
    endtask

    task automatic set_cnt(input logic [7:0] hs, s, m, h, yd, wm);
        @(negedge clk);
        c_hs = hs; c_s = s; c_m = m; c_h = h; c_yd = yd; c_wm = wm;
    endtask

    // watchdog
    initial begin
        for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd_check(4'h0, 8'h00, "R1");
        rd_check(4'h7, 8'h00, "R1");
        rd_check(4'h8, 8'h00, "R1");
        pin_check(1'b0, "R1");

        // R12 square wave while alarms disabled
        pulse(0, 49);
        pin_check(1'b0, "R12");
        pulse(0, 1);
        pin_check(1'b1, "R12");
        pulse(0, 50);
        pin_check(1'b0, "R12");

        // R3 days counted while alarms disabled; other ticks ignored
        pulse(4, 3);
        pulse(1, 2);
        rd_check(4'h7, 8'h03, "R3");

        // R2 register access
        for (int i = 8; i < 16; i++) wr(4'(i), 8'(8'h30 + i));
        for (int i = 8; i < 16; i++) rd_check(4'(i), 8'(8'h30 + i), "R2");
        wr(4'h3, 8'h5A);
        rd_check(4'h3, 8'h00, "R2");

        // R6 daily alarm
        wr(4'h8, 8'h00);
        wr(4'h0, 8'h04);
        wr(4'h9, 8'h12); wr(4'hA, 8'h34); wr(4'hB, 8'h56); wr(4'hC, 8'h07);
        wr(4'h8, 8'h90);
        rd_check(4'h0, 8'h04, "R6");
        set_cnt(8'h12, 8'h34, 8'h56, 8'h07, 8'h44, 8'h21);
        rd_check(4'h0, 8'h06, "R6");
        pin_check(1'b1, "R11");
        // R9 held match does not retrigger after clear
        wr(4'h0, 8'h04);
        rd_check(4'h0, 8'h04, "R9");
        pin_check(1'b0, "R11");
        set_cnt(8'h13, 8'h34, 8'h56, 8'h07, 8'hC2, 8'h05);
        rd_check(4'h0, 8'h04, "R6");
        set_cnt(8'h12, 8'h34, 8'h56, 8'h07, 8'hC2, 8'h05);
        rd_check(4'h0, 8'h06, "R6");

        // R10 flag event in the same cycle as a clearing write
        wr(4'h0, 8'h04);
        set_cnt(8'h11, 8'h34, 8'h56, 8'h07, 8'h00, 8'h00);
        @(negedge clk);
        c_hs = 8'h12; bus_wr = 1; bus_addr = 4'h0; bus_wdata = 8'h04;
        @(negedge clk);
        bus_wr = 0;
        rd_check(4'h0, 8'h06, "R10");

        // R9 type none never fires
        wr(4'h0, 8'h04);
        wr(4'h8, 8'h80);
        set_cnt(8'h11, 8'h34, 8'h56, 8'h07, 8'h00, 8'h00);
        set_cnt(8'h12, 8'h34, 8'h56, 8'h07, 8'h00, 8'h00);
        rd_check(4'h0, 8'h04, "R9");

        // R8 dated alarm, year and weekday ignored
        wr(4'hD, 8'h15); wr(4'hE, 8'h03);
        wr(4'h8, 8'hB0);
        rd_check(4'h0, 8'h04, "R8");
        set_cnt(8'h12, 8'h34, 8'h56, 8'h07, 8'h95, 8'hA3);
        rd_check(4'h0, 8'h06, "R8");
        wr(4'h0, 8'h04);
        set_cnt(8'h12, 8'h34, 8'h56, 8'h07, 8'h95, 8'hA4);
        rd_check(4'h0, 8'h04, "R8");
        set_cnt(8'h12, 8'h34, 8'h56, 8'h07, 8'h55, 8'h03);
        rd_check(4'h0, 8'h06, "R8");
        wr(4'h0, 8'h04);

        // R7 weekday mask
        wr(4'h8, 8'hA0);
        wr(4'hE, 8'h08);
        set_cnt(8'h12, 8'h34, 8'h56, 8'h07, 8'h55, 8'hA1);
        rd_check(4'h0, 8'h04, "R7");
        set_cnt(8'h12, 8'h34, 8'h56, 8'h07, 8'h55, 8'h61);
        rd_check(4'h0, 8'h06, "R7");
        wr(4'h0, 8'h04);
        set_cnt(8'h12, 8'h34, 8'h56, 8'h07, 8'h55, 8'h81);
        rd_check(4'h0, 8'h04, "R7");

        // R4 overflow in seconds unit; R3 unit select
        set_cnt(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        wr(4'h8, 8'h82);
        wr(4'h7, 8'h98);
        pulse(1, 1);
        rd_check(4'h7, 8'h99, "R3");
        pulse(1, 1);
        rd_check(4'h7, 8'h00, "R4");
        rd_check(4'h0, 8'h05, "R4");
        pin_check(1'b1, "R11");
        pulse(0, 2);
        rd_check(4'h7, 8'h00, "R3");
        wr(4'h0, 8'h04);
        pin_check(1'b0, "R11");

        // R5 timer alarm
        wr(4'hF, 8'h05);
        wr(4'h7, 8'h03);
        wr(4'h8, 8'h89);
        pulse(0, 1);
        rd_check(4'h0, 8'h04, "R5");
        pulse(0, 1);
        rd_check(4'h0, 8'h05, "R5");
        pin_check(1'b1, "R11");

        // R11 interrupt enable removed releases pin
        wr(4'h8, 8'h09);
        pin_check(1'b0, "R11");

        // R12 back to square wave, phase restarts released
        wr(4'h0, 8'h00);
        pin_check(1'b0, "R12");
        pulse(0, 50);
        pin_check(1'b1, "R12");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule